// File: doc/BRIEF.md
# SPI Backlight Dimming Receiver

This block receives brightness commands for a display backlight over a four-wire serial link and turns them into a pulse-width-modulated drive signal. A host shifts in one 16-bit word per transfer in SPI mode 0: the clock idles low and data is sampled on its rising edge. Chip select is active high. The nominal serial clock is 1 MHz. The block runs on a much faster system clock, samples the serial pins through two-flop synchronisers and detects the serial clock edges in that domain.

A command carries an enable flag and a brightness value from 0 to 250, where 250 is full brightness. The value is used directly as the number of high cycles in a PWM period of 250 system-clock steps. A word of all zeros switches the backlight off. A received word waits in a pending slot until the current PWM period ends, so the output never shows a shortened or stretched pulse. During a transfer the block shifts out the word that was last applied, which lets a host read back the active setting.

Top module: `bl_spi_dimmer`

## Requirements
- R1: While reset is asserted and after it is released, before any command takes effect, pwm_out, bl_enable and miso are all 0.
- R2: A transfer is shifted in MSB first on rising serial-clock edges while cs is high. It is accepted when cs falls after exactly 16 rising edges.
- R3: A transfer with fewer or more than 16 rising edges is discarded, and so are serial-clock edges while cs is low. The applied setting and the word read back on miso stay unchanged.
- R4: Bit 14 of the word is the enable flag and bits 7:0 hold the brightness. With the flag set and a brightness v of 1 to 250, pwm_out is high for exactly v of every 250 system-clock cycles.
- R5: With the flag set, a brightness above 250 is clamped to 250, so pwm_out stays high throughout.
- R6: A word with bit 14 clear, including the all-zero word, holds pwm_out low and drives bl_enable to 0. bl_enable always equals bit 14 of the applied word.
- R7: An accepted word takes effect only at a PWM period boundary. Rising edges of pwm_out stay exactly 250 cycles apart, and every pulse has the width of either the old setting or the new one.
- R8: While cs is high, miso presents the last applied 16-bit word MSB first. The first bit is valid before the first rising serial-clock edge, and miso advances after each falling edge. While cs is low, miso is 0.
- R9: Bit 15 and bits 13:8 of the word have no effect on pwm_out or bl_enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also clocks the PWM counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| cs | input | 1 | Chip select, active high |
| miso | output | 1 | Serial read-back of the applied word |
| pwm_out | output | 1 | Backlight PWM drive |
| bl_enable | output | 1 | Enable flag of the applied word |

## Verification
The bench sends transfers one clock short and one clock long, and also toggles the serial clock with chip select low. A receiver that counted loosely would take up the brightness of those transfers, and the bench would see a changed high count and a wrong read-back word. It changes the duty from 50 to 200 in the middle of a period while timing every pulse. A design that loaded the new duty straight away would produce a pulse of neither width, or a rise that breaks the 250-cycle spacing. Brightness codes of 251 and 255, stray upper bits, the enable flag cleared with a non-zero value, and the end points 1, 249 and 250 check the clamp and the decode. An off-by-one in the counter compare or the clamp would show up as a high count one cycle off.

// File: rtl/bl_spi_dimmer.sv
module bl_spi_dimmer #(
  parameter int FRAME_BITS  = 16,
  parameter int EN_BIT      = 14,
  parameter int PWM_STEPS   = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic cs,
  output logic miso,
  output logic pwm_out,
  output logic bl_enable
);
  localparam int VAL_W = $clog2(PWM_STEPS + 1);
  localparam int CNT_W = $clog2(PWM_STEPS);
  localparam int BC_W  = $clog2(FRAME_BITS + 2);
  localparam logic [BC_W-1:0]  BC_FULL = BC_W'(FRAME_BITS);
  localparam logic [BC_W-1:0]  BC_OVER = BC_W'(FRAME_BITS + 1);
  localparam logic [VAL_W-1:0] TOP     = VAL_W'(PWM_STEPS);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(PWM_STEPS - 1);

  logic [SYNC_STAGES-1:0] sck_sync, mosi_sync, cs_sync;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sync  <= '0;
      mosi_sync <= '0;
      cs_sync   <= '0;
      sck_d     <= 1'b0;
      cs_d      <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs};
      sck_d     <= sck_sync[SYNC_STAGES-1];
      cs_d      <= cs_sync[SYNC_STAGES-1];
    end

  wire sck_s    = sck_sync[SYNC_STAGES-1];
  wire mosi_s   = mosi_sync[SYNC_STAGES-1];
  wire cs_s     = cs_sync[SYNC_STAGES-1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_rise  = cs_s & ~cs_d;
  wire cs_fall  = ~cs_s & cs_d;

  logic [BC_W-1:0]       bcnt;
  logic [FRAME_BITS-1:0] rx_sr, tx_sr;
  logic [FRAME_BITS-1:0] pend_cmd, applied;
  logic                  pend_vld;
  logic [CNT_W-1:0]      pwm_cnt;
  logic [VAL_W-1:0]      duty;

  wire frame_ok = cs_fall && (bcnt == BC_FULL);
  wire wrap     = (pwm_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bcnt  <= '0;
      rx_sr <= '0;
    end else if (cs_rise) begin
      bcnt <= '0;
    end else if (cs_s && sck_rise) begin
      rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
      if (bcnt != BC_OVER) bcnt <= bcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_sr <= '0;
    else if (cs_rise) tx_sr <= applied;
    else if (cs_s && sck_fall) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};

  assign miso = cs_s & tx_sr[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_cmd <= '0;
      pend_vld <= 1'b0;
    end else if (frame_ok) begin
      pend_cmd <= rx_sr;
      pend_vld <= 1'b1;
    end else if (wrap) begin
      pend_vld <= 1'b0;
    end

  wire [VAL_W-1:0] raw_val  = pend_cmd[VAL_W-1:0];
  wire [VAL_W-1:0] clamped  = (raw_val > TOP) ? TOP : raw_val;
  wire [VAL_W-1:0] new_duty = pend_cmd[EN_BIT] ? clamped : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwm_cnt <= '0;
      duty    <= '0;
      applied <= '0;
    end else begin
      pwm_cnt <= wrap ? '0 : pwm_cnt + 1'b1;
      if (wrap && pend_vld) begin
        duty    <= new_duty;
        applied <= pend_cmd;
      end
    end

  assign pwm_out   = VAL_W'(pwm_cnt) < duty;
  assign bl_enable = applied[EN_BIT];
endmodule

module bl_spi_dimmer_chk #(
  parameter int PWM_STEPS = 250,
  parameter int CNT_W = 8,
  parameter int VAL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_out,
  input logic             bl_enable,
  input logic             miso,
  input logic             cs_s,
  input logic [CNT_W-1:0] cnt,
  input logic [VAL_W-1:0] duty
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (!pwm_out && !bl_enable && !miso));
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n) cnt < CNT_W'(PWM_STEPS));
  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n) duty <= VAL_W'(PWM_STEPS));
  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n) !bl_enable |-> !pwm_out);
  p_edge_r7: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwm_out) |-> cnt == '0);
  p_stable_r7: assert property (@(posedge clk) disable iff (!rst_n) (cnt != '0) |-> $stable(duty));
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |-> !miso);
endmodule

bind bl_spi_dimmer bl_spi_dimmer_chk #(
  .PWM_STEPS(PWM_STEPS), .CNT_W(CNT_W), .VAL_W(VAL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .bl_enable(bl_enable),
  .miso(miso), .cs_s(cs_s), .cnt(pwm_cnt), .duty(duty)
);

// File: tb/bl_spi_dimmer_test.sv
`timescale 1ns/1ps
module bl_spi_dimmer_test;
  logic clk = 0, rst_n = 0, sck = 0, mosi = 0, cs = 0;
  wire  miso, pwm_out, bl_enable;
  int   checks = 0, errors = 0;
  bit   done = 0;
  logic [15:0] applied_exp = '0;
  logic [15:0] rx_miso = '0;
  localparam int HALF = 20;

  always #2 clk = ~clk;

  bl_spi_dimmer uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs(cs),
    .miso(miso), .pwm_out(pwm_out), .bl_enable(bl_enable)
  );

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int exp_duty(logic [15:0] w);
    int v = int'(w[7:0]);
    if (!w[14]) return 0;
    return (v > 250) ? 250 : v;
  endfunction

  task automatic send(logic [15:0] w, int nbits, bit sel);
    cs = sel;
    rx_miso = '0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HALF);
      if (i < 16) rx_miso[15-i] = miso;
      sck = 1;
      wait_clk(HALF);
      sck = 0;
    end
    wait_clk(HALF);
    cs = 0;
    mosi = 0;
    wait_clk(HALF);
  endtask

  task automatic measure(output int h);
    h = 0;
    repeat (250) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  task automatic apply(logic [15:0] w);
    send(w, 16, 1'b1);
    chk("R8 read-back of previous word", int'(rx_miso), int'(applied_exp));
    applied_exp = w;
    wait_clk(600);
  endtask

  task automatic t_level(logic [15:0] w, string tag);
    int h;
    apply(w);
    measure(h);
    chk({tag, " high cycles"}, h, exp_duty(w));
    chk({tag, " enable flag"}, int'(bl_enable), int'(w[14]));
  endtask

  task automatic t_reset();
    int h;
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 bl_enable after reset", int'(bl_enable), 0);
    chk("R1 miso after reset", int'(miso), 0);
    measure(h);
    chk("R1 no pulses before a command", h, 0);
  endtask

  task automatic t_levels();
    t_level(16'h4001, "R2 R4 value 1");
    t_level(16'h4064, "R2 R4 value 100");
    t_level(16'h40F9, "R4 value 249");
    t_level(16'h40FA, "R4 value 250");
  endtask

  task automatic t_clamp();
    t_level(16'h40FB, "R5 value 251");
    t_level(16'h40FF, "R5 value 255");
  endtask

  task automatic t_disable();
    t_level(16'h4080, "R6 setup on");
    t_level(16'h0080, "R6 flag clear");
    t_level(16'h0000, "R6 all zero");
  endtask

  task automatic t_upper_bits();
    t_level(16'hFF64, "R9 upper bits set");
    t_level(16'h8050, "R9 bit15 without flag");
  endtask

  task automatic t_bad_frames();
    int h;
    apply(16'h4032);
    send(16'h40C8, 15, 1'b1);
    send(16'h40C8, 17, 1'b1);
    send(16'h40C8, 16, 1'b0);
    wait_clk(600);
    measure(h);
    chk("R3 duty after bad transfers", h, 50);
    chk("R3 enable after bad transfers", int'(bl_enable), 1);
    send(16'h4010, 16, 1'b1);
    chk("R3 read-back after bad transfers", int'(rx_miso), 16'h4032);
    applied_exp = 16'h4010;
    wait_clk(600);
  endtask

  task automatic monitor(int n, output int bad, output int seen_new);
    bit armed = 0;
    bit last = 0;
    int w = 0, gap = 0;
    bad = 0;
    seen_new = 0;
    repeat (n) begin
      @(negedge clk);
      gap++;
      if (pwm_out && !last) begin
        if (armed && gap != 250) bad++;
        gap = 0;
        armed = 1;
        w = 0;
      end
      if (pwm_out) w++;
      if (!pwm_out && last && armed) begin
        if (w == 200) seen_new++;
        else if (w != 50) bad++;
      end
      last = pwm_out;
    end
  endtask

  task automatic t_boundary();
    int bad, seen_new;
    apply(16'h4032);
    fork
      send(16'h40C8, 16, 1'b1);
      monitor(3000, bad, seen_new);
    join
    chk("R7 malformed pulses during update", bad, 0);
    chk("R7 new width reached", int'(seen_new > 0), 1);
    chk("R8 read-back during update", int'(rx_miso), 16'h4032);
    applied_exp = 16'h40C8;
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_levels();
    t_clamp();
    t_disable();
    t_upper_bits();
    t_bad_frames();
    t_boundary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule